// File: doc/BRIEF.md
# Barrel Shift Execution Unit

This block is the shift stage of a 32-bit processor datapath. It is purely combinational. It takes one source operand and produces a shifted or rotated copy on a separate result output, so the source is never overwritten. It also produces the negative, zero and carry flags that a flag-setting form of the operation would write. It supports five operations:

- arithmetic shift right;
- logical shift left;
- logical shift right;
- rotate right;
- a one-place rotate right that passes through the incoming carry.

The shift amount comes from one of two places. One is a 5-bit immediate field. The other is the low byte of a register operand, which the decode stage places on an 8-bit port, so the register amount can be anywhere from 0 to 255. Amounts of 32 and above have fully defined results. Instruction decode, the register file, condition evaluation and writeback all sit outside the block. The block only reports, through `flag_we`, whether its flag outputs should be written.

Top module: `barrel_shift_unit`

## Requirements
- R1: `opcode` selects the operation: 0 is arithmetic shift right, 1 is logical shift left, 2 is logical shift right, 3 is rotate right and 4 is rotate right through carry. Codes 5 to 7 pass `op_a` to `result` unchanged and leave the carry equal to `carry_in`.
- R2: When `amt_src` is 1, the shift amount is the unsigned 8-bit value on `reg_amt` (0 to 255). When `amt_src` is 0, it is taken from `imm_amt`.
- R3: Immediate decoding is as follows. For the two right shifts (codes 0 and 2), an `imm_amt` of 0 means an amount of 32 and any other value is used as is. For logical shift left, an `imm_amt` of 0 is a plain move with the carry unchanged. For rotate right, an `imm_amt` of 0 leaves the operand and the carry unchanged.
- R4: A logical shift (left or right) by 32 or more gives a result of zero. At exactly 32, the carry is the last bit moved out: bit 0 for a left shift and bit 31 for a right shift. Above 32, the carry is 0.
- R5: An arithmetic shift right by 32 or more fills every result bit with bit 31 of `op_a`, and the carry equals that same bit.
- R6: Rotate right uses the amount modulo 32. For any nonzero amount, including multiples of 32, the carry equals bit 31 of the result.
- R7: Rotate right through carry ignores both amount inputs. Its result is `{carry_in, op_a[31:1]}` and its carry is `op_a[0]`.
- R8: For codes 0 to 3, an effective amount of zero (a register amount of 0, or the zero cases of R3) makes `result` equal to `op_a` and the carry equal to `carry_in`.
- R9: For shifts by 1 to 31, the carry is the last bit moved out of the operand.
- R10: When `set_flags` is 1, `flag_we` is 1 and the flags follow the result: `flag_n` equals `result[31]`, `flag_z` is 1 exactly when `result` is zero, and `flag_c` is the carry defined above.
- R11: When `set_flags` is 0, `flag_we`, `flag_n`, `flag_z` and `flag_c` are all 0, and `result` is the same as it would be with `set_flags` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Source operand to be shifted or rotated |
| amt_src | input | 1 | Amount source: 0 immediate, 1 register byte |
| imm_amt | input | 5 | Immediate shift amount field |
| reg_amt | input | 8 | Low byte of the register holding the amount |
| opcode | input | 3 | Operation select (see R1) |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Request flag update from this operation |
| result | output | 32 | Shifted or rotated value |
| flag_we | output | 1 | Flag outputs are to be written |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |

## Verification
The bench targets the following amounts, each with a known failure it would expose:

- Amounts just around the word width (31, 32, 33) and far above it (255). A saturation cap placed one step off would return the wrong carry at 32 or leak operand bits at 33.
- Immediate zero on each operation. A decoder that does not turn 0 into 32 for the right shifts would pass the operand through instead of clearing or sign-filling it.
- A zero register amount. A design that forced the carry from the shifter instead of keeping `carry_in` would corrupt the carry here.
- Rotates by multiples of 32. An unmasked amount would zero the result instead of returning the operand.
- Rotate through carry with both carry values. A swapped insertion bit would show up in `result[31]`.

Random operands, amounts and codes, compared with a bit-at-a-time reference model, cover the rest of the space.

// File: rtl/bsu_pkg.sv
// Package: shared types and sizes for the barrel shift execution unit.
// Assumes a power-of-two data width; opcode encoding is fixed by the
// decode stage that drives the unit.
package bsu_pkg;

    localparam int BSU_DATA_W = 32;
    localparam int BSU_AMT_W  = 8;

    typedef enum logic [2:0] {
        OP_ASR = 3'd0,
        OP_LSL = 3'd1,
        OP_LSR = 3'd2,
        OP_ROR = 3'd3,
        OP_RRX = 3'd4
    } bsu_op_e;

endpackage

// File: rtl/bsu_amount_sel.sv
// Module: bsu_amount_sel
// Chooses the effective shift amount from the immediate field or the
// register byte. Assumes AMT_W is wide enough to hold DATA_W. An immediate
// of zero means a full-width shift for the two right shifts.
module bsu_amount_sel
    import bsu_pkg::*;
#(
    parameter int DATA_W = BSU_DATA_W,
    parameter int AMT_W  = BSU_AMT_W,
    parameter int IMM_W  = $clog2(DATA_W)
) (
    input  logic             amt_src,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  bsu_op_e          opcode,
    output logic [AMT_W-1:0] amt
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic             is_rshift;
    logic [AMT_W-1:0] imm_dec;

    // Decode the immediate field into an amount.
    always_comb begin
        is_rshift = (opcode == OP_ASR) || (opcode == OP_LSR);
        if (is_rshift && (imm_amt == '0)) begin
            imm_dec = FULL_AMT;
        end else begin
            imm_dec = AMT_W'(imm_amt);
        end
    end

    // Pick the amount source.
    always_comb begin
        amt = amt_src ? reg_amt : imm_dec;
    end

    // Immediate amounts never exceed the data width.
    always_comb begin
        if (!amt_src) begin
            AST_IMM_RANGE: assert (amt <= FULL_AMT); // R3
        end
    end

endmodule

// File: rtl/bsu_shift_core.sv
// Module: bsu_shift_core
// Computes the shifted or rotated result and the carry out.
// Shifts run through a logarithmic right shifter on an extended word:
// {fill, operand, guard}. Left shifts reuse it by reversing the bits.
// The amount is capped at DATA_W+1, so bit 0 of the shifted word is the
// last bit moved out. Rotates use a separate log rotator indexed by
// amount mod DATA_W. Assumes DATA_W is a power of two.
module bsu_shift_core
    import bsu_pkg::*;
#(
    parameter int DATA_W = BSU_DATA_W,
    parameter int AMT_W  = BSU_AMT_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [AMT_W-1:0]  amt,
    input  bsu_op_e           opcode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);

    localparam int SH_W  = $clog2(DATA_W);
    localparam int SAT_W = SH_W + 1;
    localparam int EXT_W = 2 * DATA_W + 2;
    localparam logic [AMT_W-1:0] CAP_AMT  = AMT_W'(DATA_W + 1);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    // Reverse the bit order of a data word.
    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    logic [SAT_W-1:0]  sat_amt;
    logic [DATA_W-1:0] sh_src;
    logic              sh_fill;
    logic [EXT_W-1:0]  sh_stg [0:SAT_W];
    logic [DATA_W-1:0] rot_stg [0:SH_W];
    logic [DATA_W-1:0] sh_out;
    logic              sh_c;
    logic [DATA_W-1:0] rot_out;
    logic              amt_zero;

    // Cap the amount so that the fill region covers every large shift.
    always_comb begin
        sat_amt = (amt > CAP_AMT) ? SAT_W'(DATA_W + 1) : amt[SAT_W-1:0];
    end

    // Select the shifter input and the fill bit for the operation.
    always_comb begin
        unique case (opcode)
            OP_LSL:  begin sh_src = bit_rev(op_a); sh_fill = 1'b0;           end
            OP_ASR:  begin sh_src = op_a;          sh_fill = op_a[DATA_W-1]; end
            default: begin sh_src = op_a;          sh_fill = 1'b0;           end
        endcase
    end

    assign sh_stg[0]  = {{(DATA_W+1){sh_fill}}, sh_src, 1'b0};
    assign rot_stg[0] = op_a;

    // Logarithmic right shifter, one stage per amount bit.
    for (genvar k = 0; k < SAT_W; k++) begin : g_shift
        localparam int STEP = 1 << k;
        assign sh_stg[k+1] = sat_amt[k] ? (sh_stg[k] >> STEP) : sh_stg[k];
    end

    // Logarithmic right rotator, amount taken modulo DATA_W.
    for (genvar k = 0; k < SH_W; k++) begin : g_rot
        localparam int STEP = 1 << k;
        assign rot_stg[k+1] = amt[k]
            ? {rot_stg[k][STEP-1:0], rot_stg[k][DATA_W-1:STEP]}
            : rot_stg[k];
    end

    assign sh_out  = sh_stg[SAT_W][DATA_W:1];
    assign sh_c    = sh_stg[SAT_W][0];
    assign rot_out = rot_stg[SH_W];

    // Final operation mux: result and carry out.
    always_comb begin
        amt_zero = (amt == '0);
        res      = op_a;
        c_out    = carry_in;
        unique case (opcode)
            OP_ASR, OP_LSR: begin
                if (!amt_zero) begin
                    res   = sh_out;
                    c_out = sh_c;
                end
            end
            OP_LSL: begin
                if (!amt_zero) begin
                    res   = bit_rev(sh_out);
                    c_out = sh_c;
                end
            end
            OP_ROR: begin
                if (!amt_zero) begin
                    res   = rot_out;
                    c_out = rot_out[DATA_W-1];
                end
            end
            OP_RRX: begin
                res   = {carry_in, op_a[DATA_W-1:1]};
                c_out = op_a[0];
            end
            default: begin
                res   = op_a;
                c_out = carry_in;
            end
        endcase
    end

    // Guards on the shifter and rotator against the operation rules.
    always_comb begin
        if (((opcode == OP_LSL) || (opcode == OP_LSR)) && (amt >= FULL_AMT)) begin
            AST_LOGIC_CLEARS: assert (res == '0); // R4
        end
        if ((opcode == OP_ASR) && (amt >= FULL_AMT)) begin
            AST_ASR_SIGN_FILL: assert ((res == {DATA_W{op_a[DATA_W-1]}}) && (c_out == op_a[DATA_W-1])); // R5
        end
        if ((opcode == OP_RRX)) begin
            AST_RRX_THROUGH_CARRY: assert ((res[DATA_W-1] == carry_in) && (c_out == op_a[0])); // R7
        end
        if ((opcode != OP_RRX) && (amt == '0)) begin
            AST_ZERO_AMT_PASS: assert ((res == op_a) && (c_out == carry_in)); // R8
        end
        if ((opcode == OP_ROR) && (amt != '0)) begin
            AST_ROR_CARRY_MSB: assert (c_out == res[DATA_W-1]); // R6
        end
    end

endmodule

// File: rtl/bsu_flag_gen.sv
// Module: bsu_flag_gen
// Forms the negative, zero and carry flags from the result. All flag
// outputs are forced low when no update is requested, so a stale value
// cannot be latched downstream.
module bsu_flag_gen
    import bsu_pkg::*;
#(
    parameter int DATA_W = BSU_DATA_W
) (
    input  logic [DATA_W-1:0] res,
    input  logic              c_new,
    input  logic              set_flags,
    output logic              flag_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c
);

    // Derive and gate the flags.
    always_comb begin
        flag_we = set_flags;
        flag_n  = set_flags & res[DATA_W-1];
        flag_z  = set_flags & (res == '0);
        flag_c  = set_flags & c_new;
    end

    // Flag outputs track the result when enabled and stay quiet otherwise.
    always_comb begin
        if (!set_flags) begin
            AST_FLAGS_QUIET: assert (!flag_we && !flag_n && !flag_z && !flag_c); // R11
        end else begin
            AST_NZ_FOLLOW: assert ((flag_n == res[DATA_W-1]) && (flag_z == (res == '0))); // R10
        end
    end

endmodule

// File: rtl/barrel_shift_unit.sv
// Module: barrel_shift_unit (top)
// Combinational shift stage of a 32-bit datapath: amount selection,
// shift/rotate core and flag generation. Decode supplies the low byte of
// the amount register. The unit holds no state.
module barrel_shift_unit
    import bsu_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic        amt_src,
    input  logic [4:0]  imm_amt,
    input  logic [7:0]  reg_amt,
    input  logic [2:0]  opcode,
    input  logic        carry_in,
    input  logic        set_flags,
    output logic [31:0] result,
    output logic        flag_we,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c
);

    localparam int DATA_W = BSU_DATA_W;
    localparam int AMT_W  = BSU_AMT_W;
    localparam int IMM_W  = $clog2(DATA_W);

    bsu_op_e           op_sel;
    logic [AMT_W-1:0]  eff_amt;
    logic [DATA_W-1:0] core_res;
    logic              core_c;

    // Interpret the opcode port as the operation type.
    always_comb begin
        op_sel = bsu_op_e'(opcode);
    end

    bsu_amount_sel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W),
        .IMM_W  (IMM_W)
    ) u_amount_sel (
        .amt_src (amt_src),
        .imm_amt (imm_amt),
        .reg_amt (reg_amt),
        .opcode  (op_sel),
        .amt     (eff_amt)
    );

    bsu_shift_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_shift_core (
        .op_a     (op_a),
        .amt      (eff_amt),
        .opcode   (op_sel),
        .carry_in (carry_in),
        .res      (core_res),
        .c_out    (core_c)
    );

    bsu_flag_gen #(
        .DATA_W (DATA_W)
    ) u_flag_gen (
        .res       (core_res),
        .c_new     (core_c),
        .set_flags (set_flags),
        .flag_we   (flag_we),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_c    (flag_c)
    );

    assign result = core_res;

    // Unknown opcodes behave as a move.
    always_comb begin
        if (opcode > 3'd4) begin
            AST_SPARE_OPCODE_MOVE: assert (result == op_a); // R1
        end
    end

endmodule

// File: tb/barrel_shift_unit_bench.sv
// Bench for barrel_shift_unit: directed corner cases followed by seeded
// random stimulus, compared against a bit-at-a-time reference model.
module barrel_shift_unit_bench;

    logic        clk;
    logic        rst_n;
    logic [31:0] op_a;
    logic        amt_src;
    logic [4:0]  imm_amt;
    logic [7:0]  reg_amt;
    logic [2:0]  opcode;
    logic        carry_in;
    logic        set_flags;
    logic [31:0] result;
    logic        flag_we, flag_n, flag_z, flag_c;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;

    barrel_shift_unit u_barrel_shift_unit (
        .op_a      (op_a),
        .amt_src   (amt_src),
        .imm_amt   (imm_amt),
        .reg_amt   (reg_amt),
        .opcode    (opcode),
        .carry_in  (carry_in),
        .set_flags (set_flags),
        .result    (result),
        .flag_we   (flag_we),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_c    (flag_c)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Print the single summary line.
    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        n_cycles <= n_cycles + 1;
        if (n_cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", n_cycles);
            report();
            $finish;
        end
    end

    // Reference: effective amount from the requirements.
    function automatic int ref_amount(input logic [2:0] opc, input logic src,
                                      input logic [4:0] imm, input logic [7:0] rg);
        if (src) return int'(rg);
        if ((opc == 3'd0 || opc == 3'd2) && imm == 5'd0) return 32;
        return int'(imm);
    endfunction

    // Reference: one bit step at a time.
    function automatic void ref_model(input logic [31:0] a, input logic [2:0] opc,
                                      input int amt, input logic cin,
                                      output logic [31:0] r, output logic c);
        r = a;
        c = cin;
        if (opc == 3'd4) begin
            r = {cin, a[31:1]};
            c = a[0];
        end else if (opc <= 3'd3) begin
            for (int i = 0; i < amt; i++) begin
                case (opc)
                    3'd0: begin c = r[0];  r = {r[31], r[31:1]}; end
                    3'd1: begin c = r[31]; r = {r[30:0], 1'b0};  end
                    3'd2: begin c = r[0];  r = {1'b0, r[31:1]};  end
                    default: begin c = r[0]; r = {r[0], r[31:1]}; end
                endcase
            end
        end
    endfunction

    // Drive one vector at the falling edge, settle, compare all outputs.
    task automatic apply(input string tag, input logic [31:0] a, input logic [2:0] opc,
                         input logic src, input logic [4:0] imm, input logic [7:0] rg,
                         input logic cin, input logic sf);
        logic [31:0] er;
        logic        ec, en, ez, ewe;
        @(negedge clk);
        op_a = a; opcode = opc; amt_src = src; imm_amt = imm;
        reg_amt = rg; carry_in = cin; set_flags = sf;
        #5;
        ref_model(a, opc, ref_amount(opc, src, imm, rg), cin, er, ec);
        ewe = sf;
        en  = sf & er[31];
        ez  = sf & (er == 32'd0);
        ec  = sf & ec;
        n_checks++;
        if (result !== er || flag_we !== ewe || flag_n !== en || flag_z !== ez || flag_c !== ec) begin
            n_fail++;
            $display("FAIL %s: actual res=%h we=%b n=%b z=%b c=%b expected res=%h we=%b n=%b z=%b c=%b",
                     tag, result, flag_we, flag_n, flag_z, flag_c, er, ewe, en, ez, ec);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        op_a = '0; opcode = '0; amt_src = 1'b0; imm_amt = '0;
        reg_amt = '0; carry_in = 1'b0; set_flags = 1'b0;
        repeat (3) @(posedge clk);
        // Reset state: all-zero inputs, flags masked (R11).
        #5;
        n_checks++;
        if (result !== 32'd0 || flag_we || flag_n || flag_z || flag_c) begin
            n_fail++;
            $display("FAIL R11 reset: actual res=%h flags=%b%b%b%b expected 0 and 0000",
                     result, flag_we, flag_n, flag_z, flag_c);
        end
        rst_n = 1'b1;

        // R1: each operation, plus spare codes.
        apply("R1 asr",   32'h8000_00F0, 3'd0, 1'b1, 5'd0, 8'd4, 1'b0, 1'b1);
        apply("R1 lsl",   32'h0000_00F1, 3'd1, 1'b1, 5'd0, 8'd4, 1'b0, 1'b1);
        apply("R1 spare5", 32'h1234_5678, 3'd5, 1'b1, 5'd0, 8'd9, 1'b1, 1'b1);
        apply("R1 spare7", 32'hDEAD_BEEF, 3'd7, 1'b0, 5'd3, 8'd0, 1'b0, 1'b1);
        // R2: register byte up to 255, source selection.
        apply("R2 reg255", 32'hF0F0_0001, 3'd3, 1'b1, 5'd1, 8'd255, 1'b0, 1'b1);
        apply("R2 srcimm", 32'h0000_0F00, 3'd2, 1'b0, 5'd8, 8'd1, 1'b0, 1'b1);
        // R3: immediate zero cases.
        apply("R3 asr0",  32'h8000_0000, 3'd0, 1'b0, 5'd0, 8'd0, 1'b0, 1'b1);
        apply("R3 lsr0",  32'h8000_0001, 3'd2, 1'b0, 5'd0, 8'd0, 1'b0, 1'b1);
        apply("R3 lsl0",  32'h8000_0001, 3'd1, 1'b0, 5'd0, 8'd0, 1'b1, 1'b1);
        apply("R3 ror0",  32'h0000_0001, 3'd3, 1'b0, 5'd0, 8'd0, 1'b0, 1'b1);
        // R4: logical shifts at 31, 32, 33, 255.
        apply("R4 lsl32", 32'h0000_0001, 3'd1, 1'b1, 5'd0, 8'd32, 1'b0, 1'b1);
        apply("R4 lsr32", 32'h8000_0000, 3'd2, 1'b1, 5'd0, 8'd32, 1'b0, 1'b1);
        apply("R4 lsl33", 32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0, 8'd33, 1'b1, 1'b1);
        apply("R4 lsr255", 32'hFFFF_FFFF, 3'd2, 1'b1, 5'd0, 8'd255, 1'b1, 1'b1);
        apply("R9 lsr31", 32'hC000_0000, 3'd2, 1'b1, 5'd0, 8'd31, 1'b0, 1'b1);
        // R5: arithmetic saturation, both signs.
        apply("R5 asr40n", 32'h8000_0000, 3'd0, 1'b1, 5'd0, 8'd40, 1'b0, 1'b1);
        apply("R5 asr200p", 32'h7FFF_FFFF, 3'd0, 1'b1, 5'd0, 8'd200, 1'b1, 1'b1);
        // R6: rotate modulo 32 and multiples of 32.
        apply("R6 ror32", 32'h8000_0001, 3'd3, 1'b1, 5'd0, 8'd32, 1'b0, 1'b1);
        apply("R6 ror64", 32'h0000_0001, 3'd3, 1'b1, 5'd0, 8'd64, 1'b1, 1'b1);
        apply("R6 ror36", 32'h0000_0010, 3'd3, 1'b1, 5'd0, 8'd36, 1'b0, 1'b1);
        // R7: rotate through carry with both carries, amounts ignored.
        apply("R7 rrx c1", 32'h0000_0002, 3'd4, 1'b1, 5'd7, 8'd99, 1'b1, 1'b1);
        apply("R7 rrx c0", 32'hFFFF_FFFF, 3'd4, 1'b0, 5'd7, 8'd99, 1'b0, 1'b1);
        // R8: register amount zero keeps carry.
        apply("R8 asr0c1", 32'h8000_0000, 3'd0, 1'b1, 5'd0, 8'd0, 1'b1, 1'b1);
        apply("R8 lsl0c0", 32'h0000_0000, 3'd1, 1'b1, 5'd0, 8'd0, 1'b0, 1'b1);
        // R9: in-range carry is last bit out.
        apply("R9 lsl1", 32'h8000_0000, 3'd1, 1'b0, 5'd1, 8'd0, 1'b0, 1'b1);
        apply("R9 asr5", 32'h0000_0010, 3'd0, 1'b0, 5'd5, 8'd0, 1'b0, 1'b1);
        // R10 / R11: flags enabled vs masked with identical data.
        apply("R10 zero", 32'h0000_0001, 3'd2, 1'b1, 5'd0, 8'd1, 1'b0, 1'b1);
        apply("R11 mask", 32'h8000_0001, 3'd2, 1'b1, 5'd0, 8'd1, 1'b0, 1'b0);

        // Seeded random sweep across all requirements (R1..R11 mix).
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra;
            logic [7:0]  rg;
            ra = $urandom();
            rg = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(28, 36)) : 8'($urandom());
            apply("R1 random", ra, 3'($urandom_range(0, 7)), 1'($urandom()),
                  5'($urandom()), rg, 1'($urandom()), 1'($urandom()));
        end

        report();
        $finish;
    end

endmodule